// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block derives the two clocks an audio serial port needs when it acts as clock master: a bit clock and a frame clock. Both come from a fast master clock through two cascaded dividers. The bit-clock divider counts master-clock cycles per bit-clock period. The frame divider counts bit-clock periods per frame. A third output, a one-cycle frame-start strobe, tells a serializer where each frame begins.

All settings live in one 32-bit control word, loaded through a single write strobe. The word holds an enable bit, a framing-mode bit and the two divider fields. The frame clock takes one of two shapes. In standard stereo framing it is a square wave that is low for the first half of the frame and high for the second half. In multi-slot framing it is a pulse one bit-clock wide at the start of each frame.

Every write restarts both dividers, so the first frame after a write is always complete. Typical settings for 16-bit stereo are a frame divider of 32 with bit-clock dividers of 768, 384, 256, 192, 128, 64 and 32. These correspond to 8, 16, 24, 32, 48, 96 and 192 kHz. The 44.1 kHz and 88.2 kHz rates reuse the 48 kHz and 96 kHz values. For 32-bit stereo the frame divider is 64 and each bit-clock divider is halved.

Top module: `audio_clkgen`

## Requirements
- R1: Control bit 0 enables the generator. While this bit is 0, the outputs bclk, lrclk and frame_start all stay low.
- R2: Control bit 1 selects the framing mode: 0 gives standard stereo framing and 1 gives single-pulse multi-slot framing.
- R3: The frame divider L is control bits 10:2 and the bit-clock divider B is control bits 23:11. Bits 31:24 have no effect on the outputs.
- R4: Each bclk period lasts B master-clock cycles. The period starts low, and the high phase lasts floor(B/2) cycles, so the falling edge of bclk marks the start of a period.
- R5: One frame lasts L bclk periods.
- R6: In standard framing, lrclk is low for the first L - floor(L/2) bclk periods of a frame and high for the remaining floor(L/2). It changes only at the start of a bclk period, which is a falling edge.
- R7: In multi-slot framing, lrclk is high during the first bclk period of each frame and low during all other periods.
- R8: frame_start is high for exactly one master-clock cycle, the first cycle of each frame. In that cycle bclk is low.
- R9: A write clears both dividers and drives all outputs low in the cycle after the write edge. Frame index 0 appears in the cycle after that.
- R10: A divider field value of 0 or 1 behaves as 2.
- R11: After reset the control word is zero and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word value |
| bclk | output | 1 | Serial bit clock |
| lrclk | output | 1 | Frame / word-select clock |
| frame_start | output | 1 | One-cycle strobe at the start of each frame |

## Verification
The assertions are checked on every cycle. They confirm that the outputs stay quiet while the block is disabled and right after a write, and that frame_start is a single-cycle pulse that falls in a bit-clock low phase. They also confirm that lrclk only moves while bclk is low, and that in multi-slot framing frame_start coincides with the lrclk pulse. Only the bench's scenarios can show the exact waveform shapes. These include the divider periods, the odd-divider duty split, the frame length, the half-frame placement, and the clamping of small divider values. They also include the restart that happens when a write lands in the middle of a frame. The bench compares every output against a model of the requirements, cycle by cycle, for each configuration.

// File: rtl/audio_clkgen.sv
module audio_clkgen #(
  parameter int LDIV_W   = 9,
  parameter int BDIV_W   = 13,
  parameter int LDIV_LSB = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic        bclk,
  output logic        lrclk,
  output logic        frame_start
);
  localparam int BDIV_LSB = LDIV_LSB + LDIV_W;
  localparam int CTRL_W   = BDIV_LSB + BDIV_W;

  logic [CTRL_W-1:0] ctrl_q;
  logic [BDIV_W-1:0] mcnt;
  logic [LDIV_W-1:0] bcnt;

  wire unused_hi = ^cfg_wdata[31:CTRL_W];

  wire              en   = ctrl_q[0];
  wire              tdm  = ctrl_q[1];
  wire [LDIV_W-1:0] lraw = ctrl_q[BDIV_LSB-1:LDIV_LSB];
  wire [BDIV_W-1:0] braw = ctrl_q[CTRL_W-1:BDIV_LSB];

  wire [LDIV_W-1:0] ldiv = (lraw < LDIV_W'(2)) ? LDIV_W'(2) : lraw;
  wire [BDIV_W-1:0] bdiv = (braw < BDIV_W'(2)) ? BDIV_W'(2) : braw;

  wire mwrap = (mcnt == bdiv - BDIV_W'(1));
  wire bwrap = (bcnt == ldiv - LDIV_W'(1));

  wire bclk_d = (mcnt >= bdiv - (bdiv >> 1));
  wire lr_d   = tdm ? (bcnt == '0) : (bcnt >= ldiv - (ldiv >> 1));
  wire fs_d   = (mcnt == '0) && (bcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      mcnt        <= '0;
      bcnt        <= '0;
      bclk        <= 1'b0;
      lrclk       <= 1'b0;
      frame_start <= 1'b0;
    end else if (cfg_we || !en) begin
      if (cfg_we) ctrl_q <= cfg_wdata[CTRL_W-1:0];
      mcnt        <= '0;
      bcnt        <= '0;
      bclk        <= 1'b0;
      lrclk       <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      bclk        <= bclk_d;
      lrclk       <= lr_d;
      frame_start <= fs_d;
      mcnt        <= mwrap ? '0 : mcnt + BDIV_W'(1);
      if (mwrap) bcnt <= bwrap ? '0 : bcnt + LDIV_W'(1);
    end
  end
endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_we,
  input logic en,
  input logic tdm,
  input logic bclk,
  input logic lrclk,
  input logic frame_start
);
  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cfg_we) |=> (!bclk && !lrclk && !frame_start));

  p_fs_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  p_fs_bclk_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !bclk);

  p_tdm_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tdm && frame_start) |-> lrclk);

  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (!bclk && !lrclk && !frame_start));

  p_lr_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lrclk) |-> !bclk);
endmodule

bind audio_clkgen audio_clkgen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .en(ctrl_q[0]), .tdm(ctrl_q[1]),
  .bclk(bclk), .lrclk(lrclk), .frame_start(frame_start)
);

// File: tb/audio_clkgen_tb.sv
`timescale 1ns/1ps
module audio_clkgen_tb;
  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic bclk, lrclk, frame_start;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  audio_clkgen u_dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
                      .bclk(bclk), .lrclk(lrclk), .frame_start(frame_start));

  function automatic logic [31:0] mk(bit en, bit tdm, int l, int b, logic [7:0] hi);
    return {hi, 24'(b) << 11} | (32'(l) << 2) | (32'(tdm) << 1) | 32'(en);
  endfunction

  localparam logic [31:0] VEC [7] = '{
    32'h0000_2081,   // R2 standard, L=32 B=4
    32'h0000_2823,   // R2 multi-slot, L=8 B=5
    32'h0000_181D,   // R4 odd B=3, R6 odd L=7
    32'h0000_0013,   // R10 B=0 -> 2, multi-slot L=4
    32'h0000_0805,   // R10 L=1, B=1 -> 2,2
    32'hA501_0081,   // R3 junk upper bits, L=32 B=32 (16-bit 192 kHz)
    32'h0000_2022    // R1 disabled, multi-slot L=8 B=4
  };

  task automatic apply(logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = w;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    checks++;
    if (bclk || lrclk || frame_start) begin
      errors++;
      $display("FAIL R9 outputs after write: got %b%b%b expected 000", bclk, lrclk, frame_start);
    end
  endtask

  task automatic check_frames(logic [31:0] w, int nframes);
    int l = int'(w[10:2]);
    int b = int'(w[23:11]);
    bit en = w[0], tdm = w[1];
    bit eb = 0, el = 0, ef = 0;
    if (l < 2) l = 2;
    if (b < 2) b = 2;
    for (int k = 0; k < nframes * l * b; k++) begin
      int m = k % b;
      int p = (k / b) % l;
      logic xb = en && (m >= b - b / 2);
      logic xl = en && (tdm ? (p == 0) : (p >= l - l / 2));
      logic xf = en && (m == 0) && (p == 0);
      @(posedge clk);
      @(negedge clk);
      if (bclk !== xb && !eb) begin
        eb = 1;
        $display("FAIL %s bclk cfg=%h idx=%0d: got %b expected %b", en ? "R4" : "R1", w, k, bclk, xb);
      end
      if (lrclk !== xl && !el) begin
        el = 1;
        $display("FAIL %s lrclk cfg=%h idx=%0d: got %b expected %b", tdm ? "R7" : "R6", w, k, lrclk, xl);
      end
      if (frame_start !== xf && !ef) begin
        ef = 1;
        $display("FAIL R8 frame_start cfg=%h idx=%0d: got %b expected %b", w, k, frame_start, xf);
      end
    end
    checks += 3;
    errors += int'(eb) + int'(el) + int'(ef);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state, and it holds with no write
    check_frames(32'h0, 20);
    checks++;
    if (bclk || lrclk || frame_start) begin
      errors++;
      $display("FAIL R11 reset outputs: got %b%b%b expected 000", bclk, lrclk, frame_start);
    end

    // R5 frame length covered by two whole frames per vector
    for (int i = 0; i < 7; i++) begin
      apply(VEC[i]);
      check_frames(VEC[i], 2);
    end

    // R9 rewrite in mid-frame restarts at index 0
    apply(mk(1, 0, 6, 7, 8'h00));
    repeat (23) @(posedge clk);
    apply(mk(1, 0, 6, 7, 8'h00));
    check_frames(mk(1, 0, 6, 7, 8'h00), 2);

    // R1 disabling mid-run stops every output
    apply(mk(1, 1, 4, 3, 8'h00));
    repeat (5) @(posedge clk);
    apply(mk(0, 1, 4, 3, 8'h00));
    check_frames(mk(0, 1, 4, 3, 8'h00), 3);

    // R3 upper bits alone do not change a running configuration
    apply(mk(1, 0, 4, 6, 8'hFF));
    check_frames(mk(1, 0, 4, 6, 8'h00), 2);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule